// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block is the digital front end of a two-channel 12-bit converter. An 8-bit parallel bus feeds it. Each channel holds a 12-bit staging word, written in two pieces: a low byte and a high nibble. Each channel also holds a 12-bit output word that drives the converter code pins. Two address lines pick which piece of which channel a write lands in. The write is qualified by active-low select and write strobes.

An active-low transfer strobe moves both staging words into both output words in the same cycle, so the two channels change together. If a write is qualified while the transfer strobe is low, the path becomes transparent. The written piece reaches its output word on the same clock edge. An active-low clear input empties every register. Its assertion acts asynchronously and its release is synchronised to the clock.

All logic is synchronous to `clk`. A qualified write acts on every edge at which it is present.

Top module: `dac_dual_loader`

## Requirements
- R1: While `rst` is high at a clock edge, all staging and output words become zero, so both code outputs read 0 after that edge.
- R2: A qualified write (`cs_n`=0, `wr_n`=0, `upd_n`=1) with `addr`=2'b00 (channel A) or 2'b10 (channel B) puts `data[7:0]` into bits 7..0 of that channel's staging word. Bits 11..8 keep their value, and neither code output changes.
- R3: A qualified write with `addr`=2'b01 (channel A) or 2'b11 (channel B) puts `data[3:0]` into bits 11..8 of that staging word, with `data[3]` as the most significant bit. `data[7:4]` is ignored and bits 7..0 keep their value.
- R4: With `upd_n`=1, an edge at which `cs_n` or `wr_n` is high changes no staging word and no output word.
- R5: Driving `clr_n` low zeroes all staging and output words at once, without waiting for a clock edge, and overrides every other input. Writes and transfers at the first two edges after `clr_n` returns high are ignored.
- R6: With `upd_n`=0, `wr_n`=0 and `cs_n`=1, both output words load their channel's staging word at the same edge, and no staging word changes.
- R7: With `upd_n`=0, `cs_n`=0 and `wr_n`=0, the addressed staging piece is written as in R2/R3. After that same edge, both output words equal their updated staging words.
- R8: With `upd_n`=0 and `wr_n`=1, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low clear of all registers (asynchronous assertion) |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| upd_n | input | 1 | Active-low transfer strobe |
| addr | input | 2 | Bit 1 selects the channel (0=A, 1=B); bit 0 selects the piece (0=low byte, 1=high nibble) |
| data | input | 8 | Parallel data bus |
| dac_a_code | output | 12 | Channel A output word |
| dac_b_code | output | 12 | Channel B output word |

## Verification
Split writes with the transfer strobe high show that staging and output words are separate. The output must stay put until a transfer. High-nibble writes carry junk in `data[7:4]`, and alternating byte and nibble writes show that each piece keeps the other half intact. Transfers with select high are compared against transparent writes with select low, which separates copying the old staging word from following the new one. Writes with `wr_n` high during a transfer show that a transfer needs the write strobe. A clear that drops in the middle of a held write, followed by its release, checks that the asynchronous clear takes effect at once and that writes are locked out for exactly two edges after release.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  localparam int unsigned NCH    = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned HI_W   = CODE_W - DATA_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef code_t [NCH-1:0]   code_arr_t;
endpackage

// File: rtl/dac_clr_sync.sv
module dac_clr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic clr_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign clr_q = chain[STAGES-1];
endmodule

// File: rtl/dac_in_regs.sv
module dac_in_regs
  import dac_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_q,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] data,
  output code_arr_t         in_q,
  output code_arr_t         in_nxt
);
  logic wr_ok;
  assign wr_ok = !cs_n && !wr_n;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic sel_lo, sel_hi;
    assign sel_lo = wr_ok && (addr[1] == ch[0]) && !addr[0];
    assign sel_hi = wr_ok && (addr[1] == ch[0]) &&  addr[0];

    always_comb begin
      in_nxt[ch] = in_q[ch];
      if (sel_lo) in_nxt[ch][DATA_W-1:0]      = data;
      if (sel_hi) in_nxt[ch][CODE_W-1:DATA_W] = data[HI_W-1:0];
    end

    always_ff @(posedge clk or posedge clr_q) begin
      if (clr_q)    in_q[ch] <= '0;
      else if (rst) in_q[ch] <= '0;
      else          in_q[ch] <= in_nxt[ch];
    end

    AST_NIBBLE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst || clr_q)
      sel_hi |=> $stable(in_q[ch][DATA_W-1:0])); // R3
    AST_BYTE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst || clr_q)
      sel_lo |=> $stable(in_q[ch][CODE_W-1:DATA_W])); // R2
  end

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst || clr_q)
    (cs_n || wr_n) |=> $stable(in_q)); // R4
endmodule

// File: rtl/dac_out_regs.sv
module dac_out_regs
  import dac_loader_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr_q,
  input  logic      cs_n,
  input  logic      wr_n,
  input  logic      upd_n,
  input  code_arr_t in_q,
  input  code_arr_t in_nxt,
  output code_arr_t dac_q
);
  logic xfer, transp;
  assign xfer   = !upd_n && !wr_n &&  cs_n;
  assign transp = !upd_n && !wr_n && !cs_n;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk or posedge clr_q) begin
      if (clr_q)       dac_q[ch] <= '0;
      else if (rst)    dac_q[ch] <= '0;
      else if (transp) dac_q[ch] <= in_nxt[ch];
      else if (xfer)   dac_q[ch] <= in_q[ch];
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) clr_q |-> (dac_q == '0)); // R5
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst || clr_q)
    (upd_n || wr_n) |=> $stable(dac_q)); // R8
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst || clr_q)
    xfer |=> (dac_q == $past(in_q))); // R6
  AST_TRANSP_FOLLOW: assert property (@(posedge clk) disable iff (rst || clr_q)
    transp |=> (dac_q == in_q)); // R7
endmodule

// File: rtl/dac_dual_loader.sv
module dac_dual_loader
  import dac_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              upd_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] dac_a_code,
  output logic [CODE_W-1:0] dac_b_code
);
  logic      clr_q;
  code_arr_t in_q, in_nxt, dac_q;

  dac_clr_sync #(.STAGES(2)) i_clr (
    .clk(clk), .clr_n(clr_n), .clr_q(clr_q)
  );

  dac_in_regs i_in (
    .clk(clk), .rst(rst), .clr_q(clr_q), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .data(data), .in_q(in_q), .in_nxt(in_nxt)
  );

  dac_out_regs i_out (
    .clk(clk), .rst(rst), .clr_q(clr_q), .cs_n(cs_n), .wr_n(wr_n),
    .upd_n(upd_n), .in_q(in_q), .in_nxt(in_nxt), .dac_q(dac_q)
  );

  assign dac_a_code = dac_q[0];
  assign dac_b_code = dac_q[1];

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (clr_q)
    rst |=> (dac_a_code == '0 && dac_b_code == '0)); // R1
endmodule

// File: tb/test_dac_dual_loader.sv
module test_dac_dual_loader;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst = 1'b1, clr_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] data = 8'h00;
  logic [11:0] dac_a_code, dac_b_code;

  int total = 0, bad = 0;
  string cur_req = "R1";
  int m_in [2];
  int m_dac[2];
  int m_hold = 0;

  always #(CLK_PER/2) clk = ~clk;

  dac_dual_loader i_dac_dual_loader (
    .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .upd_n(upd_n), .addr(addr), .data(data),
    .dac_a_code(dac_a_code), .dac_b_code(dac_b_code)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  // reference model, evaluated at each rising edge
  always @(posedge clk) begin
    int nx[2];
    if (!clr_n) begin
      m_in = '{0, 0}; m_dac = '{0, 0}; m_hold = 2;
    end else if (m_hold > 0) begin
      m_hold--; m_in = '{0, 0}; m_dac = '{0, 0};
    end else if (rst) begin
      m_in = '{0, 0}; m_dac = '{0, 0};
    end else begin
      nx = m_in;
      if (!cs_n && !wr_n) begin
        if (addr[0]) nx[addr[1]] = (nx[addr[1]] & 'hFF) | (int'(data & 8'h0F) << 8);
        else         nx[addr[1]] = (nx[addr[1]] & 'hF00) | int'(data);
      end
      if (!upd_n && !wr_n) m_dac = cs_n ? m_in : nx;
      m_in = nx;
    end
    #(CLK_PER/4);
    check({cur_req, " chA"}, int'(dac_a_code), m_dac[0]);
    check({cur_req, " chB"}, int'(dac_b_code), m_dac[1]);
  end

  task automatic drive(input logic c, input logic w, input logic u,
                       input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = c; wr_n = w; upd_n = u; addr = a; data = d;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 2'b00, 8'h00);
  endtask

  initial begin
    #(CLK_PER*2000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1", int'(dac_a_code), 0);
    check("R1", int'(dac_b_code), 0);

    cur_req = "R2";  drive(0, 0, 1, 2'b00, 8'hA5); idle();
    check("R2", int'(dac_a_code), 0);
    cur_req = "R3";  drive(0, 0, 1, 2'b01, 8'hF3); idle();
    check("R3", int'(dac_a_code), 0);
    cur_req = "R2";  drive(0, 0, 1, 2'b10, 8'h5C);
    cur_req = "R3";  drive(0, 0, 1, 2'b11, 8'hAE); idle();
    cur_req = "R4";  drive(1, 0, 1, 2'b00, 8'hFF); drive(0, 1, 1, 2'b11, 8'hFF); idle();
    cur_req = "R8";  drive(1, 1, 0, 2'b00, 8'h00); drive(0, 1, 0, 2'b01, 8'h77); idle();
    check("R8", int'(dac_a_code), 0);
    cur_req = "R6";  drive(1, 0, 0, 2'b00, 8'h00); idle();
    check("R6", int'(dac_a_code), 'h3A5);
    check("R6", int'(dac_b_code), 'hE5C);
    cur_req = "R2";  drive(0, 0, 1, 2'b00, 8'h11); idle();
    check("R2", int'(dac_a_code), 'h3A5);
    cur_req = "R7";  drive(0, 0, 0, 2'b11, 8'h97); idle();
    check("R7", int'(dac_a_code), 'h311);
    check("R7", int'(dac_b_code), 'h75C);
    drive(0, 0, 0, 2'b10, 8'h22); drive(0, 0, 0, 2'b01, 8'h0C); idle();
    check("R7", int'(dac_a_code), 'hC11);
    check("R7", int'(dac_b_code), 'h722);

    cur_req = "R5";  drive(0, 0, 0, 2'b00, 8'h66);
    #(CLK_PER/4 + 1);
    clr_n = 1'b0;
    #1;
    check("R5", int'(dac_a_code), 0);
    check("R5", int'(dac_b_code), 0);
    @(negedge clk); @(negedge clk);
    clr_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5", int'(dac_a_code), 'h066);
    idle();
    cur_req = "R1";  rst = 1'b1; @(negedge clk); rst = 1'b0; idle();
    check("R1", int'(dac_a_code), 0);
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule